// File: doc/BRIEF.md
# UART Transmit Holding Stage

This block sits between a host and the serializer of a 16550-style UART transmitter. The host offers bytes on a valid/ready write channel. In FIFO mode the bytes go into a transmit queue of `DEPTH` entries (16 by default). In non-FIFO mode the same storage holds only one byte, so it acts as a single holding register. The serializer takes bytes over a second valid/ready channel, and a load happens only in a cycle where it signals that it is idle.

The block drives two status flags that mean different things. `hold_empty` tells the host that the holding stage has space: in FIFO mode it is set while the queue holds no byte, and in non-FIFO mode it is set once the held byte has moved into the shifter. `tx_idle` is set only when the holding stage holds nothing and the shifter also reports that it is not busy. An interrupt request follows `hold_empty` while its enable is on.

Back-pressure works as follows. A byte on the write channel is taken only in a cycle where `wr_valid` and `wr_ready` are both high. If `wr_valid` is high while `wr_ready` is low, the byte is discarded and is not retried. Any change of `fifo_mode_en` flushes all stored bytes on the next clock edge, and `wr_ready` and `sh_valid` stay low during that flush cycle. The serializer must raise `sh_busy` in the cycle after it accepts a load, and must keep `sh_busy` high until that byte has been shifted out.

Top module: `tx_hold_stage`

## Requirements
- R1: After reset, `hold_empty`=1, `tx_idle`=1 and `wr_ready`=1, and `hold_irq` equals `hold_irq_en`.
- R2: In non-FIFO mode (`fifo_mode_en`=0), the stage holds one byte. After a write is accepted, `hold_empty` is 0 from the next cycle, and `wr_ready` stays 0 while that byte is held.
- R3: In non-FIFO mode, `hold_empty` returns to 1 in the cycle after the held byte is loaded into the shifter.
- R4: In FIFO mode (`fifo_mode_en`=1), `hold_empty` is 1 exactly when the queue holds zero bytes. The queue holds up to `DEPTH` bytes, and `wr_ready` is 0 while it is full.
- R5: A write offered while `wr_ready`=0 is discarded. The bytes already stored are delivered unchanged and in order.
- R6: `tx_idle` is 1 only when the holding stage is empty and `sh_busy`=0.
- R7: `hold_irq` = `hold_empty` AND `hold_irq_en`.
- R8: A load happens in each cycle where `sh_valid` and `sh_ready` are both high. The same cycle removes the oldest byte, so bytes reach `sh_data` in the order they were written, and a write and a load may share a cycle.
- R9: A change of `fifo_mode_en` discards every stored byte. `hold_empty` is 1 in the following cycle, and the discarded bytes never reach the shifter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode_en | input | 1 | 1 = queue of DEPTH bytes, 0 = single holding register |
| hold_irq_en | input | 1 | Enable for the holding-empty interrupt request |
| wr_valid | input | 1 | Host offers a byte |
| wr_data | input | DATA_W | Byte offered by the host |
| wr_ready | output | 1 | Stage can take a byte this cycle |
| sh_valid | output | 1 | A byte is available for the shifter |
| sh_data | output | DATA_W | Oldest stored byte |
| sh_ready | input | 1 | Shifter is idle and can load |
| sh_busy | input | 1 | Shifter is holding or sending a byte |
| hold_empty | output | 1 | Holding-stage-empty flag |
| tx_idle | output | 1 | Holding stage and shifter both empty |
| hold_irq | output | 1 | Holding-empty interrupt request |

## Verification
The assertions check several rules on every cycle. In non-FIFO mode, a write clears `hold_empty` and a load sets it again. A discarded write leaves the fill level unchanged. Each load lowers the level by one unless a write happens in the same cycle. A mode change leaves the stage empty. Only the bench scenarios can show the byte order across the serializer channel, the full FIFO capacity, that flushed bytes never appear at the serializer, and how `tx_idle` tracks the shifter as it finishes a byte.

// File: rtl/tx_hold_pkg.sv
package tx_hold_pkg;
  localparam int unsigned BYTE_BITS = 8;
  localparam int unsigned QUEUE_DEPTH = 16;
endpackage

// File: rtl/tx_byte_fifo.sv
module tx_byte_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [LVL_W-1:0]  limit,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic [LVL_W-1:0]  level,
  output logic              empty,
  output logic              space
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty    = (level == '0);
  assign space    = (level < limit);
  assign pop_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end

  assert_count_in_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (level <= limit));

  assert_pop_drains_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !flush) |=> (level == $past(level) - LVL_W'(1)));
endmodule

// File: rtl/tx_status_flags.sv
module tx_status_flags (
  input  logic store_empty,
  input  logic shifter_busy,
  input  logic irq_en,
  output logic hold_empty,
  output logic tx_idle,
  output logic hold_irq
);
  assign hold_empty = store_empty;
  assign tx_idle    = store_empty & ~shifter_busy;
  assign hold_irq   = store_empty & irq_en;
endmodule

// File: rtl/tx_hold_stage.sv
module tx_hold_stage
  import tx_hold_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_BITS,
  parameter int unsigned DEPTH  = QUEUE_DEPTH,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_mode_en,
  input  logic              hold_irq_en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              sh_valid,
  output logic [DATA_W-1:0] sh_data,
  input  logic              sh_ready,
  input  logic              sh_busy,
  output logic              hold_empty,
  output logic              tx_idle,
  output logic              hold_irq
);
  logic             mode_q, flush, push, sh_load, empty, space;
  logic [LVL_W-1:0] limit, level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= fifo_mode_en;
  end

  assign flush    = fifo_mode_en ^ mode_q;
  assign limit    = fifo_mode_en ? LVL_W'(DEPTH) : LVL_W'(1);
  assign wr_ready = space & ~flush;
  assign push     = wr_valid & wr_ready;
  assign sh_valid = ~empty & ~flush;
  assign sh_load  = sh_valid & sh_ready;

  tx_byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .limit(limit),
    .push(push), .push_data(wr_data), .pop(sh_load), .pop_data(sh_data),
    .level(level), .empty(empty), .space(space)
  );

  tx_status_flags u_flags (
    .store_empty(empty), .shifter_busy(sh_busy), .irq_en(hold_irq_en),
    .hold_empty(hold_empty), .tx_idle(tx_idle), .hold_irq(hold_irq)
  );

  assert_write_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode_en && push) |=> !hold_empty);

  assert_load_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode_en && sh_load && !flush) |=> hold_empty);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !sh_load && !flush) |=> (level == $past(level)));

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> hold_empty);
endmodule

// File: tb/test_tx_hold_stage.sv
module test_tx_hold_stage;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int SHIFT_CYC  = 4;

  logic clk = 0, rst_n = 0;
  logic fifo_mode_en = 0, hold_irq_en = 1, wr_valid = 0;
  logic [7:0] wr_data = 0, sh_data;
  logic wr_ready, sh_valid, sh_ready, sh_busy, hold_empty, tx_idle, hold_irq;
  logic hold_off = 1;
  int   busy_cnt;
  int   errors = 0, checks = 0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_hold_stage #(.DATA_W(8), .DEPTH(DEPTH)) i_tx_hold_stage (
    .clk(clk), .rst_n(rst_n), .fifo_mode_en(fifo_mode_en), .hold_irq_en(hold_irq_en),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .sh_valid(sh_valid), .sh_data(sh_data), .sh_ready(sh_ready), .sh_busy(sh_busy),
    .hold_empty(hold_empty), .tx_idle(tx_idle), .hold_irq(hold_irq)
  );

  assign sh_busy  = (busy_cnt != 0);
  assign sh_ready = !sh_busy && !hold_off;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= 0;
    else if (sh_valid && sh_ready) busy_cnt <= SHIFT_CYC;
    else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: every load is compared with the scoreboard (R8)
  always @(posedge clk) begin
    if (rst_n && sh_valid && sh_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected load: actual=%h expected=none", sh_data);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (sh_data !== e) begin
          errors++;
          $display("FAIL R8 order: actual=%h expected=%h", sh_data, e);
        end
      end
    end
  end

  task automatic put(input logic [7:0] d, input logic exp_ready, input string tag);
    @(negedge clk);
    wr_valid = 1; wr_data = d;
    chk(wr_ready, exp_ready, tag);
    if (wr_ready) exp_q.push_back(d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_valid = 0;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      wr_valid = 0;
      if (exp_q.size() == 0) break;
    end
    chk(exp_q.size() == 0, 1'b1, "R8 drain");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(hold_empty, 1, "R1 hold_empty");
    chk(tx_idle, 1, "R1 tx_idle");
    chk(wr_ready, 1, "R1 wr_ready");
    chk(hold_irq, 1, "R1 R7 hold_irq");

    // non-FIFO mode
    put(8'hA5, 1, "R2 accept");
    idle(1);
    chk(hold_empty, 0, "R2 hold_empty");
    chk(wr_ready, 0, "R2 wr_ready");
    chk(hold_irq, 0, "R7 irq low");
    chk(tx_idle, 0, "R6 tx_idle busy");
    put(8'h11, 0, "R5 dropped");
    idle(1);
    chk(hold_empty, 0, "R5 still held");
    hold_off = 0;
    idle(1);
    chk(hold_empty, 1, "R3 hold_empty");
    chk(tx_idle, 0, "R6 shifter busy");
    idle(SHIFT_CYC + 1);
    chk(tx_idle, 1, "R6 tx_idle");
    chk(exp_q.size() == 0, 1, "R5 R8 one byte");

    // FIFO mode fill to capacity
    hold_off = 1;
    @(negedge clk); fifo_mode_en = 1;
    idle(1);
    for (int i = 0; i < DEPTH; i++) put(8'h40 + 8'(i), 1, "R4 accept");
    idle(1);
    chk(hold_empty, 0, "R4 hold_empty full");
    chk(wr_ready, 0, "R4 full");
    put(8'hEE, 0, "R5 full drop");
    hold_off = 0;
    drain();
    chk(hold_empty, 1, "R4 empty after drain");

    // simultaneous write and load
    for (int i = 0; i < 6; i++) put(8'hC0 + 8'(i), 1, "R8 stream");
    drain();
    idle(SHIFT_CYC + 2);
    chk(tx_idle, 1, "R6 idle after stream");

    // interrupt enable off
    hold_irq_en = 0;
    idle(1);
    chk(hold_irq, 0, "R7 disabled");
    hold_irq_en = 1;
    idle(1);
    chk(hold_irq, 1, "R7 enabled");

    // flush by mode change: bytes not pushed to scoreboard
    hold_off = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); wr_valid = 1; wr_data = 8'h90 + 8'(i);
    end
    idle(1);
    chk(hold_empty, 0, "R9 loaded");
    fifo_mode_en = 0;
    idle(1);
    chk(hold_empty, 1, "R9 flushed");
    hold_off = 0;
    idle(20);
    chk(sh_valid, 0, "R9 nothing delivered");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule